// File: doc/BRIEF.md
# Trigger Distribution and Throttle Supervisor

This block sits between the central trigger decision logic and a set of front-end partitions that all run on one shared bunch-crossing clock. Each cycle it may receive a level-0 accept and a level-1 accept. For every partition it forwards each accept as a registered strobe, unless that partition is held off. A partition is held off for one trigger level when any throttle input of that level that is mapped to it is raised. Dropped accepts are counted per partition. Passed level-1 accepts are counted per partition as accepted events.

A bunch counter runs up to a programmable orbit length and then wraps. Each wrap sends a bunch-count reset strobe to every partition in the same cycle. An event-count reset request is queued until the next wrap. It then goes out to every partition together with the bunch-count reset, and in that same edge it clears all accepted-event counters.

A small configuration write port sets the throttle-to-partition map, the orbit length and a per-partition run mask. This lets groups of sub-detectors run on their own.

A three-state sequencer orders the event-count reset. Its states are `SEQ_IDLE` (nothing queued), `SEQ_WAIT` (request queued, waiting for a wrap) and `SEQ_FIRE` (reset being broadcast). Its transitions are:
- `SEQ_IDLE` to `SEQ_WAIT` on a request.
- `SEQ_WAIT` to `SEQ_FIRE` on a wrap.
- `SEQ_FIRE` to `SEQ_WAIT` if a new request is present.
- `SEQ_FIRE` to `SEQ_IDLE` otherwise.

A request that arrives in `SEQ_WAIT` merges with the one already queued.

Top module: `trig_throttle_sup`

## Requirements
- R1: When `l0_acc` is high and the partition is enabled and not held off for level 0, `l0_trig_o[p]` is high in the next cycle. The same applies to `l1_acc` and `l1_trig_o[p]` for level 1. Bit p of every per-partition vector belongs to partition p.
- R2: The level-0 hold-off of partition p is the OR of all `thr_l0[i]` whose map entry selects p. A held-off partition gives no level-0 strobe, and the level-0 throttles have no effect on level-1 strobes.
- R3: The level-1 hold-off of partition p is the OR of all `thr_l1[i]` mapped to p. A held-off partition gives no level-1 strobe, and the level-1 throttles have no effect on level-0 strobes.
- R4: Map entry i (i = 0..7) is written at `cfg_addr` = i from the low 4 bits of `cfg_wdata`, where bit p selects partition p. Only a one-hot or zero value is accepted; any other value is ignored. Zero unmaps the input. At reset, input i maps to partition i mod 4.
- R5: `evt_cnt_o` holds a 24-bit counter per partition, partition p at bits [24p+23:24p]. It increments in the same edge that issues a level-1 strobe for that partition.
- R6: `lost_cnt_o` holds an 8-bit counter per partition at bits [8p+7:8p]. It adds one for each level-0 and each level-1 accept dropped by hold-off in an enabled partition, and it saturates at 255.
- R7: `bc_o` counts bunch crossings from 0. After the cycle where `bc_o` ≥ orbit length − 1, it returns to 0, and in that cycle `bcr_o` is high on all partitions at once.
- R8: A write to `cfg_addr` = 8 sets the orbit length from the low 12 bits of `cfg_wdata`. Values below 2 are ignored. The reset value is 3564.
- R9: A one-cycle `ecr_req` is held pending. `ecr_o` is then high on all partitions for exactly the cycle of the next `bcr_o`. In that cycle every `evt_cnt_o` field reads 0. `ecr_o` is low at all other times.
- R10: A write to `cfg_addr` = 9 sets the partition run mask from the low 4 bits of `cfg_wdata` (reset value all ones). A disabled partition issues no trigger strobes, and its event and lost counters do not change apart from the event-count reset.
- R11: During and right after reset, all strobes are low, `bc_o` is 0 and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l0_acc | input | 1 | Level-0 accept decision |
| l1_acc | input | 1 | Level-1 accept decision |
| thr_l0 | input | 8 | Level-0 throttle (buffer nearly full) per source |
| thr_l1 | input | 8 | Level-1 throttle per source |
| ecr_req | input | 1 | Event-count reset request pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| l0_trig_o | output | 4 | Level-0 trigger strobe per partition |
| l1_trig_o | output | 4 | Level-1 trigger strobe per partition |
| bcr_o | output | 4 | Bunch-count reset strobe per partition |
| ecr_o | output | 4 | Event-count reset strobe per partition |
| bc_o | output | 12 | Current bunch count |
| evt_cnt_o | output | 96 | Accepted-event counters, 24 bits per partition |
| lost_cnt_o | output | 32 | Lost-trigger counters, 8 bits per partition |

## Verification
Every strobe and counter goes through exactly one register. The result of an accept or throttle pattern applied in one cycle can therefore be seen right after the next rising edge. A configuration write affects the first stimulus applied after the edge that takes it. The bench drives inputs on the falling edge and samples at the following falling edge, one edge later, so each check looks at the cycle the result is due. The bunch-count and event-count resets are checked cycle by cycle: the bench steps through an orbit and compares `bc_o`, `bcr_o` and `ecr_o` on every cycle against a count it keeps itself.

// File: rtl/tts_pkg.sv
package tts_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_FIRE = 2'd2
    } seq_state_t;

    function automatic logic one_or_none(input logic [15:0] v);
        return (v & (v - 16'd1)) == 16'd0;
    endfunction

endpackage

// File: rtl/tts_cfg.sv
module tts_cfg
    import tts_pkg::*;
#(
    parameter int N_THR     = 8,
    parameter int N_PART    = 4,
    parameter int BC_W      = 12,
    parameter int ORBIT_DEF = 3564,
    parameter int AW        = 4,
    parameter int DW        = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [AW-1:0]                 addr,
    input  logic [DW-1:0]                 wdata,
    output logic [N_THR-1:0][N_PART-1:0]  thr_map,
    output logic [BC_W-1:0]               orbit_len,
    output logic [N_PART-1:0]             part_en
);

    localparam int              ORBIT_ADDR = N_THR;
    localparam int              EN_ADDR    = N_THR + 1;
    localparam logic [BC_W-1:0] ORBIT_RST  = BC_W'(ORBIT_DEF);
    localparam logic [BC_W-1:0] ORBIT_MIN  = BC_W'(2);

    logic [N_PART-1:0] wr_sel;
    logic              wr_legal;

    assign wr_sel   = wdata[N_PART-1:0];
    assign wr_legal = one_or_none(16'(wr_sel));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_THR; i++) begin
                thr_map[i] <= N_PART'(1) << (i % N_PART);
            end
        end else if (we && wr_legal) begin
            for (int i = 0; i < N_THR; i++) begin
                if (addr == AW'(i)) begin
                    thr_map[i] <= wr_sel;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            orbit_len <= ORBIT_RST;
        end else if (we && addr == AW'(ORBIT_ADDR) && wdata[BC_W-1:0] >= ORBIT_MIN) begin
            orbit_len <= wdata[BC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part_en <= '1;
        end else if (we && addr == AW'(EN_ADDR)) begin
            part_en <= wdata[N_PART-1:0];
        end
    end

    generate
        for (genvar g = 0; g < N_THR; g++) begin : g_map_chk
            AST_MAP_BAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                (we && addr == AW'(g) && !wr_legal) |=> $stable(thr_map[g])); // R4
        end
    endgenerate

    AST_ORBIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == AW'(ORBIT_ADDR) && wdata[BC_W-1:0] < ORBIT_MIN) |=> $stable(orbit_len)); // R8

endmodule

// File: rtl/tts_hold.sv
module tts_hold #(
    parameter int N_THR  = 8,
    parameter int N_PART = 4
) (
    input  logic [N_THR-1:0]              thr,
    input  logic [N_THR-1:0][N_PART-1:0]  thr_map,
    output logic [N_PART-1:0]             hold
);

    generate
        for (genvar p = 0; p < N_PART; p++) begin : g_part_or
            logic [N_THR-1:0] member;
            always_comb begin
                for (int i = 0; i < N_THR; i++) begin
                    member[i] = thr_map[i][p];
                end
            end
            assign hold[p] = |(thr & member);
        end
    endgenerate

endmodule

// File: rtl/tts_seq.sv
module tts_seq
    import tts_pkg::*;
#(
    parameter int BC_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BC_W-1:0] orbit_len,
    input  logic            ecr_req,
    output logic [BC_W-1:0] bc,
    output logic            wrap,
    output logic            fire,
    output seq_state_t      state
);

    seq_state_t state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bc <= '0;
        end else if (wrap) begin
            bc <= '0;
        end else begin
            bc <= bc + BC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            SEQ_IDLE: if (ecr_req) state_nxt = SEQ_WAIT;
            SEQ_WAIT: if (wrap)    state_nxt = SEQ_FIRE;
            SEQ_FIRE: state_nxt = ecr_req ? SEQ_WAIT : SEQ_IDLE;
            default:  state_nxt = SEQ_IDLE;
        endcase
    end

    always_comb begin
        wrap = (bc >= orbit_len - BC_W'(1));
        fire = wrap && (state == SEQ_WAIT);
    end

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_WAIT && !wrap) |=> state == SEQ_WAIT); // R9

    AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        state == SEQ_FIRE |=> state != SEQ_FIRE); // R9

endmodule

// File: rtl/tts_part.sv
module tts_part #(
    parameter int EVT_W  = 24,
    parameter int LOST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              hold_l0,
    input  logic              hold_l1,
    input  logic              l0_acc,
    input  logic              l1_acc,
    input  logic              wrap,
    input  logic              fire,
    output logic              l0_trig,
    output logic              l1_trig,
    output logic              bcr,
    output logic              ecr,
    output logic [EVT_W-1:0]  evt_cnt,
    output logic [LOST_W-1:0] lost_cnt
);

    localparam logic [LOST_W-1:0] LOST_MAX = '1;

    logic              l0_pass, l1_pass, l0_drop, l1_drop;
    logic [1:0]        drop_n;
    logic [LOST_W:0]   lost_sum;
    logic [LOST_W-1:0] lost_nxt;

    always_comb begin
        l0_pass  = en && l0_acc && !hold_l0;
        l1_pass  = en && l1_acc && !hold_l1;
        l0_drop  = en && l0_acc && hold_l0;
        l1_drop  = en && l1_acc && hold_l1;
        drop_n   = {1'b0, l0_drop} + {1'b0, l1_drop};
        lost_sum = {1'b0, lost_cnt} + (LOST_W+1)'(drop_n);
        lost_nxt = lost_sum[LOST_W] ? LOST_MAX : lost_sum[LOST_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l0_trig <= 1'b0;
            l1_trig <= 1'b0;
            bcr     <= 1'b0;
            ecr     <= 1'b0;
        end else begin
            l0_trig <= l0_pass;
            l1_trig <= l1_pass;
            bcr     <= wrap;
            ecr     <= fire;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_cnt <= '0;
        end else if (fire) begin
            evt_cnt <= '0;
        end else if (l1_pass) begin
            evt_cnt <= evt_cnt + EVT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lost_cnt <= '0;
        end else begin
            lost_cnt <= lost_nxt;
        end
    end

    AST_L0_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && l0_acc && !hold_l0) |=> l0_trig); // R1
    AST_L0_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        hold_l0 |=> !l0_trig); // R2
    AST_L1_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        hold_l1 |=> !l1_trig); // R3
    AST_EVT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && l1_trig == 1'b0 && en && l1_acc && !hold_l1) |=> evt_cnt == $past(evt_cnt) + EVT_W'(1)); // R5
    AST_LOST_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        lost_cnt == LOST_MAX |=> lost_cnt == LOST_MAX); // R6
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!l0_trig && !l1_trig && $stable(lost_cnt))); // R10

endmodule

// File: rtl/trig_throttle_sup.sv
module trig_throttle_sup
    import tts_pkg::*;
#(
    parameter int N_THR     = 8,
    parameter int N_PART    = 4,
    parameter int EVT_W     = 24,
    parameter int LOST_W    = 8,
    parameter int BC_W      = 12,
    parameter int ORBIT_DEF = 3564,
    parameter int CFG_AW    = 4,
    parameter int CFG_DW    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       l0_acc,
    input  logic                       l1_acc,
    input  logic [N_THR-1:0]           thr_l0,
    input  logic [N_THR-1:0]           thr_l1,
    input  logic                       ecr_req,
    input  logic                       cfg_we,
    input  logic [CFG_AW-1:0]          cfg_addr,
    input  logic [CFG_DW-1:0]          cfg_wdata,
    output logic [N_PART-1:0]          l0_trig_o,
    output logic [N_PART-1:0]          l1_trig_o,
    output logic [N_PART-1:0]          bcr_o,
    output logic [N_PART-1:0]          ecr_o,
    output logic [BC_W-1:0]            bc_o,
    output logic [N_PART*EVT_W-1:0]    evt_cnt_o,
    output logic [N_PART*LOST_W-1:0]   lost_cnt_o
);

    logic [N_THR-1:0][N_PART-1:0] thr_map;
    logic [BC_W-1:0]              orbit_len;
    logic [N_PART-1:0]            part_en;
    logic [N_PART-1:0]            hold_l0, hold_l1;
    logic                         wrap, fire;
    seq_state_t                   seq_state;

    tts_cfg #(
        .N_THR(N_THR), .N_PART(N_PART), .BC_W(BC_W),
        .ORBIT_DEF(ORBIT_DEF), .AW(CFG_AW), .DW(CFG_DW)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .thr_map(thr_map), .orbit_len(orbit_len), .part_en(part_en)
    );

    tts_hold #(.N_THR(N_THR), .N_PART(N_PART)) u_hold_l0 (
        .thr(thr_l0), .thr_map(thr_map), .hold(hold_l0)
    );

    tts_hold #(.N_THR(N_THR), .N_PART(N_PART)) u_hold_l1 (
        .thr(thr_l1), .thr_map(thr_map), .hold(hold_l1)
    );

    tts_seq #(.BC_W(BC_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .orbit_len(orbit_len), .ecr_req(ecr_req),
        .bc(bc_o), .wrap(wrap), .fire(fire), .state(seq_state)
    );

    generate
        for (genvar p = 0; p < N_PART; p++) begin : g_part
            tts_part #(.EVT_W(EVT_W), .LOST_W(LOST_W)) u_part (
                .clk(clk), .rst_n(rst_n), .en(part_en[p]),
                .hold_l0(hold_l0[p]), .hold_l1(hold_l1[p]),
                .l0_acc(l0_acc), .l1_acc(l1_acc),
                .wrap(wrap), .fire(fire),
                .l0_trig(l0_trig_o[p]), .l1_trig(l1_trig_o[p]),
                .bcr(bcr_o[p]), .ecr(ecr_o[p]),
                .evt_cnt(evt_cnt_o[p*EVT_W +: EVT_W]),
                .lost_cnt(lost_cnt_o[p*LOST_W +: LOST_W])
            );
        end
    endgenerate

    AST_BCR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (bcr_o == '0 || bcr_o == '1)); // R7
    AST_BCR_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bcr_o[0] |-> bc_o == '0); // R7
    AST_ECR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (ecr_o == '0 || ecr_o == '1)); // R9
    AST_ECR_WITH_BCR: assert property (@(posedge clk) disable iff (!rst_n)
        ecr_o[0] |-> bcr_o[0]); // R9
    AST_ECR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        ecr_o[0] == (seq_state == SEQ_FIRE)); // R9

endmodule

// File: tb/sim_trig_throttle_sup.sv
module sim_trig_throttle_sup;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        l0_acc = 1'b0, l1_acc = 1'b0, ecr_req = 1'b0, cfg_we = 1'b0;
    logic [7:0]  thr_l0 = '0, thr_l1 = '0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [3:0]  l0_trig_o, l1_trig_o, bcr_o, ecr_o;
    logic [11:0] bc_o;
    logic [95:0] evt_cnt_o;
    logic [31:0] lost_cnt_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    trig_throttle_sup u0 (
        .clk(clk), .rst_n(rst_n), .l0_acc(l0_acc), .l1_acc(l1_acc),
        .thr_l0(thr_l0), .thr_l1(thr_l1), .ecr_req(ecr_req),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .l0_trig_o(l0_trig_o), .l1_trig_o(l1_trig_o), .bcr_o(bcr_o), .ecr_o(ecr_o),
        .bc_o(bc_o), .evt_cnt_o(evt_cnt_o), .lost_cnt_o(lost_cnt_o)
    );

    // {thr_l0, thr_l1, l0_acc, l1_acc, expected l0 strobes, expected l1 strobes}
    localparam logic [25:0] VECS [10] = '{
        {8'h00, 8'h00, 1'b1, 1'b0, 4'b1111, 4'b0000},
        {8'h00, 8'h00, 1'b0, 1'b1, 4'b0000, 4'b1111},
        {8'h01, 8'h00, 1'b1, 1'b1, 4'b1110, 4'b1111},
        {8'h00, 8'h20, 1'b1, 1'b1, 4'b1111, 4'b1101},
        {8'h80, 8'h00, 1'b1, 1'b0, 4'b0111, 4'b0000},
        {8'h12, 8'h00, 1'b1, 1'b1, 4'b1100, 4'b1111},
        {8'hFF, 8'hFF, 1'b1, 1'b1, 4'b0000, 4'b0000},
        {8'hFF, 8'h00, 1'b0, 1'b1, 4'b0000, 4'b1111},
        {8'h00, 8'h0F, 1'b1, 1'b1, 4'b1111, 4'b0000},
        {8'h00, 8'h00, 1'b0, 1'b0, 4'b0000, 4'b0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic drive(input logic [7:0] t0, input logic [7:0] t1, input logic a0, input logic a1);
        thr_l0 = t0; thr_l1 = t1; l0_acc = a0; l1_acc = a1;
        step();
        thr_l0 = '0; thr_l1 = '0; l0_acc = 1'b0; l1_acc = 1'b0;
    endtask

    function automatic logic [31:0] evt(input int p);
        return 32'(evt_cnt_o[p*24 +: 24]);
    endfunction

    function automatic logic [31:0] lost(input int p);
        return 32'(lost_cnt_o[p*8 +: 8]);
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [31:0] e0, e1, l1v, l0v;
        int n;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 strobes in reset", {16'h0, l0_trig_o, l1_trig_o, bcr_o, ecr_o}, 32'h0);
        rst_n = 1'b1;
        chk("R11 bc after reset", 32'(bc_o), 32'h0);
        chk("R11 evt after reset", 32'(|evt_cnt_o), 32'h0);
        chk("R11 lost after reset", 32'(|lost_cnt_o), 32'h0);

        // R1 R2 R3: table walk with reset map (input i -> partition i mod 4)
        for (int i = 0; i < 10; i++) begin
            logic [25:0] v;
            v = VECS[i];
            drive(v[25:18], v[17:10], v[9], v[8]);
            chk($sformatf("R1 R2 vec %0d l0", i), 32'(l0_trig_o), 32'(v[7:4]));
            chk($sformatf("R1 R3 vec %0d l1", i), 32'(l1_trig_o), 32'(v[3:0]));
        end

        // R5: three passed level-1 accepts
        e0 = evt(0);
        for (int k = 0; k < 3; k++) drive(8'h00, 8'h00, 1'b0, 1'b1);
        chk("R5 evt count +3", evt(0), e0 + 32'd3);

        // R6: one dropped L0 and one dropped L1 in partition 0
        l0v = lost(0); l1v = lost(1);
        drive(8'h01, 8'h01, 1'b1, 1'b1);
        chk("R6 lost +2 in p0", lost(0), l0v + 32'd2);
        chk("R6 lost unchanged p1", lost(1), l1v);

        // R4: remap input 0 to partition 2, illegal write ignored, zero unmaps
        cfg_write(4'd0, 16'h0004);
        drive(8'h01, 8'h00, 1'b1, 1'b0);
        chk("R4 remap to p2", 32'(l0_trig_o), 32'b1011);
        cfg_write(4'd0, 16'h0003);
        drive(8'h01, 8'h00, 1'b1, 1'b0);
        chk("R4 illegal write ignored", 32'(l0_trig_o), 32'b1011);
        cfg_write(4'd0, 16'h0000);
        drive(8'h01, 8'h00, 1'b1, 1'b0);
        chk("R4 unmapped input", 32'(l0_trig_o), 32'b1111);

        // R10: disable partitions 1 and 3
        cfg_write(4'd9, 16'h0005);
        e0 = evt(0); e1 = evt(1); l1v = lost(1);
        drive(8'h02, 8'h00, 1'b1, 1'b1);
        chk("R10 l0 masked", 32'(l0_trig_o), 32'b0101);
        chk("R10 l1 masked", 32'(l1_trig_o), 32'b0101);
        chk("R10 evt p1 frozen", evt(1), e1);
        chk("R10 lost p1 frozen", lost(1), l1v);
        chk("R10 evt p0 counts", evt(0), e0 + 32'd1);
        cfg_write(4'd9, 16'h000F);

        // R6: saturation
        for (int k = 0; k < 140; k++) drive(8'hFF, 8'hFF, 1'b1, 1'b1);
        for (int p = 0; p < 4; p++) chk("R6 saturated", lost(p), 32'd255);
        drive(8'hFF, 8'hFF, 1'b1, 1'b1);
        chk("R6 stays saturated", lost(3), 32'd255);

        // R8 R7: orbit length 8
        cfg_write(4'd8, 16'd8);
        n = 0;
        while (bcr_o != 4'hF && n < 20) begin step(); n++; end
        chk("R7 wrap seen", 32'(bcr_o), 32'hF);
        chk("R7 bc zero at wrap", 32'(bc_o), 32'h0);
        for (int k = 1; k < 8; k++) begin
            step();
            chk("R7 bc advances", 32'(bc_o), 32'(k));
            chk("R7 no bcr mid orbit", 32'(bcr_o), 32'h0);
        end
        step();
        chk("R8 period 8 bcr", 32'(bcr_o), 32'hF);
        cfg_write(4'd8, 16'd1);
        n = 0;
        while (bcr_o != 4'hF && n < 20) begin step(); n++; end
        n = 0;
        do begin step(); n++; end while (bcr_o != 4'hF && n < 20);
        chk("R8 short orbit ignored", 32'(n), 32'd8);

        // R9: event-count reset aligned to next wrap
        step(); step();
        chk("R9 evt nonzero before", 32'(evt(0) != 0), 32'd1);
        ecr_req = 1'b1;
        step();
        ecr_req = 1'b0;
        n = 0;
        while (bcr_o != 4'hF && n < 20) begin
            chk("R9 no ecr before wrap", 32'(ecr_o), 32'h0);
            step(); n++;
        end
        chk("R9 ecr with bcr", 32'(ecr_o), 32'hF);
        chk("R9 evt cleared", 32'(|evt_cnt_o), 32'h0);
        step();
        chk("R9 ecr one cycle", 32'(ecr_o), 32'h0);
        n = 0;
        while (bcr_o != 4'hF && n < 20) begin step(); n++; end
        chk("R9 no ecr next orbit", 32'(ecr_o), 32'h0);

        done = 1'b1;
        summary();
    end

endmodule